// File: doc/BRIEF.md
# Multi-Queue Write Port Controller

This block is the write-side front end of a storage device that keeps 32 logical queues in one shared memory. Each write-clock cycle it samples an address strobe, an 8-bit address bus, an active-low write enable, a flag strobe and a data word. From these inputs it tracks which queue is selected for writing. It keeps a write pointer and a fill count for every queue, and it issues memory write commands that carry a queue index, a flat storage address and a data word.

Queue selection is a separate strobed step and does not depend on the write enable. A selection made on one edge only takes effect for writes sampled two edges later. In between, writes still go to the queue that was selected before. The same address bus also loads a 3-bit flag-group selection when the flag strobe is high. Queue selection stays blocked until the external configuration-done input is high. If the address strobe and the flag strobe are high in the same cycle, the block ignores both and latches a protocol error.

Top module: `mq_wr_port`

## Requirements
- R1: While `cfg_done_i` is low, an address strobe selects no queue, and writes that follow it produce no `mem_we_o` pulse.
- R2: A rising edge with `addr_en_i` high, `flag_stb_i` low and `cfg_done_i` high selects queue `addr_i[4:0]`, whatever the level of `wr_en_ni`. Writes sampled from the second edge after that one onward go to the selected queue.
- R3: A write sampled on the first edge after a selection goes to the previously selected queue. Before any queue has been selected, writes are discarded.
- R4: A write sampled with `wr_en_ni` low on a non-full selected queue gives a one-cycle `mem_we_o` pulse after that edge. The pulse carries `mem_q_o` = queue, `mem_addr_o` = queue*Q_DEPTH + that queue's pointer, and `mem_data_o` = the sampled data. Each queue's pointer starts at 0 and advances by one per accepted write.
- R5: A queue that has accepted Q_DEPTH writes is full. A write to it is dropped: there is no `mem_we_o`, and `overflow_o` pulses for one cycle after that edge.
- R6: `full_no` is low exactly when the queue active after the last edge is full. It updates one cycle after the edge and is high while no queue is active.
- R7: A rising edge with `flag_stb_i` high and `addr_en_i` low loads `addr_i[7:5]` into `flag_sel_o`, independent of `wr_en_ni`. Otherwise `flag_sel_o` holds its value.
- R8: A rising edge with both `addr_en_i` and `flag_stb_i` high changes neither the selection nor `flag_sel_o`, and sets `proto_err_o`. The flag stays set until reset.
- R9: After reset, `mem_we_o` and `overflow_o` are 0, `full_no` is 1, `proto_err_o` is 0, `flag_sel_o` is 0, and no queue is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_done_i | input | 1 | Configuration complete; enables queue selection |
| addr_en_i | input | 1 | Address strobe for queue selection |
| addr_i | input | 8 | [4:0] queue number, [7:5] flag-group field |
| wr_en_ni | input | 1 | Write enable, active low |
| flag_stb_i | input | 1 | Flag-group load strobe |
| data_i | input | DATA_W | Write data |
| mem_we_o | output | 1 | Storage write pulse |
| mem_q_o | output | 5 | Queue index of the write |
| mem_addr_o | output | 5+log2(Q_DEPTH) | Flat storage address |
| mem_data_o | output | DATA_W | Storage write data |
| overflow_o | output | 1 | Write to a full queue was dropped |
| full_no | output | 1 | Active queue full, active low |
| flag_sel_o | output | 3 | Latched flag-group selection |
| proto_err_o | output | 1 | Sticky strobe-clash error |

## Verification
Selection takes two edges to reach the write path. Write pulses and overflow pulses appear one cycle after the edge that sampled the write. `full_no`, `flag_sel_o` and `proto_err_o` settle one cycle after their edge. The bench drives each stimulus on a falling edge and pushes the expected command into a scoreboard before the next rising edge. A monitor compares on the falling edge after that rising edge, which is the first point where the registered result is visible. The level outputs are compared on the same falling edge against a model that applies the two-edge selection delay.

// File: rtl/mq_wr_pkg.sv
package mq_wr_pkg;
  localparam int QID_W  = 5;
  localparam int FLD_W  = 3;
  localparam int ADDR_W = QID_W + FLD_W;
  localparam int NUM_Q  = 2 ** QID_W;

  typedef logic [QID_W-1:0] qid_t;

  typedef struct packed {
    logic v;
    qid_t q;
  } qsel_t;
endpackage

// File: rtl/mq_sel_ctrl.sv
module mq_sel_ctrl
  import mq_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_done_i,
  input  logic              addr_en_i,
  input  logic              flag_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output qsel_t             act_o,
  output qsel_t             act_n_o,
  output logic [FLD_W-1:0]  flag_sel_o,
  output logic              proto_err_o
);
  qsel_t pend_q, act_q;
  logic  clash, sel_fire, flag_fire;

  assign clash     = addr_en_i & flag_stb_i;
  assign sel_fire  = addr_en_i & ~flag_stb_i & cfg_done_i;
  assign flag_fire = flag_stb_i & ~addr_en_i;

  // staged selection takes effect one edge later
  assign act_n_o = pend_q.v ? pend_q : act_q;
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      act_q       <= '0;
      flag_sel_o  <= '0;
      proto_err_o <= 1'b0;
    end else begin
      pend_q.v <= sel_fire;
      if (sel_fire) pend_q.q <= addr_i[QID_W-1:0];
      act_q <= act_n_o;
      if (flag_fire) flag_sel_o <= addr_i[ADDR_W-1 -: FLD_W];
      if (clash) proto_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mq_ptr_bank.sv
module mq_ptr_bank
  import mq_wr_pkg::*;
#(
  parameter int Q_DEPTH = 16,
  localparam int PTR_W = $clog2(Q_DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  qid_t             wr_q_i,
  output logic             full_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [NUM_Q-1:0] full_nxt_o
);
  logic [CNT_W-1:0] cnt [NUM_Q];
  logic [NUM_Q-1:0] full_now;

  assign full_o = full_now[wr_q_i];
  assign ptr_o  = cnt[wr_q_i][PTR_W-1:0];

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic inc;
    assign full_now[i]   = (cnt[i] == CNT_W'(Q_DEPTH));
    assign inc           = wr_req_i & (wr_q_i == qid_t'(i)) & ~full_now[i];
    assign full_nxt_o[i] = ((cnt[i] + CNT_W'(inc)) == CNT_W'(Q_DEPTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cnt[i] <= '0;
      else if (inc) cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/mq_wr_port.sv
module mq_wr_port
  import mq_wr_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int Q_DEPTH = 16,
  localparam int PTR_W  = $clog2(Q_DEPTH),
  localparam int MADR_W = QID_W + PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_done_i,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_ni,
  input  logic              flag_stb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mem_we_o,
  output logic [QID_W-1:0]  mem_q_o,
  output logic [MADR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              overflow_o,
  output logic              full_no,
  output logic [FLD_W-1:0]  flag_sel_o,
  output logic              proto_err_o
);
  qsel_t            act, act_n;
  logic             wr_req, q_full;
  logic [PTR_W-1:0] ptr;
  logic [NUM_Q-1:0] full_nxt;

  mq_sel_ctrl u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_done_i  (cfg_done_i),
    .addr_en_i   (addr_en_i),
    .flag_stb_i  (flag_stb_i),
    .addr_i      (addr_i),
    .act_o       (act),
    .act_n_o     (act_n),
    .flag_sel_o  (flag_sel_o),
    .proto_err_o (proto_err_o)
  );

  assign wr_req = ~wr_en_ni & act.v;

  mq_ptr_bank #(.Q_DEPTH(Q_DEPTH)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req),
    .wr_q_i     (act.q),
    .full_o     (q_full),
    .ptr_o      (ptr),
    .full_nxt_o (full_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_q_o    <= '0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      overflow_o <= 1'b0;
      full_no    <= 1'b1;
    end else begin
      mem_we_o   <= wr_req & ~q_full;
      overflow_o <= wr_req & q_full;
      if (wr_req & ~q_full) begin
        mem_q_o    <= act.q;
        mem_addr_o <= {act.q, ptr};
        mem_data_o <= data_i;
      end
      // full state of the queue active after this edge
      full_no <= ~(act_n.v & full_nxt[act_n.q]);
    end
  end
endmodule

// File: rtl/mq_wr_port_chk.sv
module mq_wr_port_chk
  import mq_wr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_ni,
  input logic              flag_stb_i,
  input logic              mem_we_o,
  input logic              overflow_o,
  input logic [FLD_W-1:0]  flag_sel_o,
  input logic              proto_err_o
);
  assert_we_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_ni == 1'b0 |=> !mem_we_o);

  assert_ovf_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_ni |=> !overflow_o);

  assert_no_we_on_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && overflow_o));

  assert_flag_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_stb_i && !addr_en_i) |=> flag_sel_o == $past(addr_i[ADDR_W-1 -: FLD_W]));

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_stb_i && !addr_en_i) |=> $stable(flag_sel_o));

  assert_clash_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_stb_i && addr_en_i) |=> proto_err_o);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind mq_wr_port mq_wr_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_en_i   (addr_en_i),
  .addr_i      (addr_i),
  .wr_en_ni    (wr_en_ni),
  .flag_stb_i  (flag_stb_i),
  .mem_we_o    (mem_we_o),
  .overflow_o  (overflow_o),
  .flag_sel_o  (flag_sel_o),
  .proto_err_o (proto_err_o)
);

// File: tb/mq_wr_port_bench.sv
`timescale 1ns/1ps
module mq_wr_port_bench;
  localparam int DW = 18;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic          ovf;
    logic [4:0]    q;
    logic [8:0]    addr;
    logic [DW-1:0] d;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_done = 1'b0, addr_en = 1'b0, wen_n = 1'b1, fstb = 1'b0;
  logic [7:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic mem_we, ovf, full_n, perr;
  logic [4:0] mem_q;
  logic [8:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [2:0] fsel;

  int checks = 0, fails = 0, we_seen = 0;
  item_t exp_q[$];

  // bench model state
  bit m_pend_v = 0, m_act_v = 0, m_err = 0;
  logic [4:0] m_pend_q = '0, m_act_q = '0;
  logic [2:0] m_flag = '0;
  int m_cnt [32];

  always #2.5 clk = ~clk;

  mq_wr_port #(.DATA_W(DW), .Q_DEPTH(DEPTH)) u_mq_wr_port (
    .clk_i(clk), .rst_ni(rst_n), .cfg_done_i(cfg_done), .addr_en_i(addr_en),
    .addr_i(addr), .wr_en_ni(wen_n), .flag_stb_i(fstb), .data_i(din),
    .mem_we_o(mem_we), .mem_q_o(mem_q), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .overflow_o(ovf), .full_no(full_n),
    .flag_sel_o(fsel), .proto_err_o(perr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each write or overflow pulse
  always @(negedge clk) begin
    if (rst_n && (mem_we || ovf)) begin
      if (mem_we) we_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected command", {mem_we, ovf}, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e.ovf) chk(ovf && !mem_we, "R5 overflow pulse", {mem_we, ovf}, 1);
        else begin
          chk(mem_we && !ovf, "R4 write pulse", {mem_we, ovf}, 2);
          chk(mem_q == e.q, "R2 queue index", mem_q, e.q);
          chk(mem_addr == e.addr, "R4 storage address", mem_addr, e.addr);
          chk(mem_data == e.d, "R4 data", mem_data, e.d);
        end
      end
    end
  end

  // driver: one write-clock cycle, model updated before the edge
  task automatic step(input bit en, input logic [7:0] a, input bit wn,
                      input bit fs, input logic [DW-1:0] d);
    bit exp_full_n;
    if (!wn && m_act_v) begin
      item_t it;
      it.q = m_act_q;
      it.d = d;
      it.addr = 9'(m_act_q) * 9'(DEPTH) + 9'(m_cnt[m_act_q]);
      it.ovf = (m_cnt[m_act_q] == DEPTH);
      if (!it.ovf) m_cnt[m_act_q]++;
      exp_q.push_back(it);
    end
    if (fs && !en) m_flag = a[7:5];
    if (fs && en) m_err = 1;
    if (m_pend_v) begin m_act_v = 1; m_act_q = m_pend_q; end
    m_pend_v = en && !fs && cfg_done;
    if (m_pend_v) m_pend_q = a[4:0];
    exp_full_n = !(m_act_v && m_cnt[m_act_q] == DEPTH);
    addr_en = en; addr = a; wen_n = wn; fstb = fs; din = d;
    @(posedge clk);
    @(negedge clk);
    chk(full_n == exp_full_n, "R6 full_no", full_n, exp_full_n);
    chk(fsel == m_flag, "R7 flag_sel", fsel, m_flag);
    chk(perr == m_err, "R8 proto_err", perr, m_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int base;
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!mem_we && !ovf, "R9 reset pulses", {mem_we, ovf}, 0);
    chk(full_n && !perr && fsel == 0, "R9 reset levels", {full_n, perr, fsel}, 5'h10);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: selection blocked while unconfigured
    step(1, 8'h03, 1, 0, '0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 18'h100 + 18'(i));
    chk(we_seen == 0, "R1 no write before configuration", we_seen, 0);
    cfg_done = 1'b1;

    // R2 select q5 with write enable active; R3 gap write discarded
    step(1, 8'h05, 0, 0, 18'h0AAA);
    step(0, 0, 0, 0, 18'h0BBB);
    chk(we_seen == 0, "R3 discard before any selection", we_seen, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 18'h1000 + 18'(i));

    // R3 gap write goes to q5, then q9
    step(1, 8'h09, 0, 0, 18'h2000);
    step(0, 0, 0, 0, 18'h2001);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 18'h3000 + 18'(i));
    // R5 overflow on full q9, R6 full_no low
    step(0, 0, 0, 0, 18'h3FFF);
    step(0, 0, 1, 0, '0);
    chk(full_n == 1'b0, "R6 full queue shows low", full_n, 0);

    // R6 reselect q5: full_no returns high
    step(1, 8'h05, 1, 0, '0);
    step(0, 0, 1, 0, '0);
    step(0, 0, 1, 0, '0);
    chk(full_n == 1'b1, "R6 non-full queue shows high", full_n, 1);

    // R7 flag strobe without write enable
    step(0, 8'hA0, 1, 1, '0);
    chk(fsel == 3'd5, "R7 flag load", fsel, 5);

    // R8 strobe clash: no reselect, no flag change
    step(1, 8'h62, 1, 1, '0);
    step(0, 0, 0, 0, 18'h4000);
    step(0, 0, 0, 0, 18'h4001);
    step(0, 0, 1, 0, '0);
    chk(fsel == 3'd5 && perr, "R8 clash ignored and flagged", {perr, fsel}, 4'hD);

    // R4 pointer per queue independent: q12 starts at zero
    step(1, 8'h0C, 1, 0, '0);
    step(0, 0, 1, 0, '0);
    base = we_seen;
    step(0, 0, 0, 0, 18'h5000);
    step(0, 0, 1, 0, '0);
    chk(we_seen == base + 1, "R4 single write pulse", we_seen, base + 1);
    step(0, 0, 1, 0, '0);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule